// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block is the feedback divider of a frequency synthesizer loop. Every rising edge of `clk` stands for one cycle of the oscillator being divided. Inside, a digital model of a dual-modulus prescaler counts those cycles and divides by either P or P+1, where P is 32 or 64. A main counter and a swallow counter count the prescaler's terminal events. While the swallow counter is non-zero, the prescaler divides by P+1. After it reaches zero, the prescaler divides by P until the main counter completes. One full period therefore lasts P×B+A input cycles. At the end of each period the divider emits a single-cycle pulse on `div_out`. The prescaler modulus request is exported on `mod_ctl`.

Ratios are written through the `load` strobe, and the divider stays in the IDLE state until the first one. A load from IDLE starts counting at once. A load while counting is staged and takes effect at the next period boundary, so the period in progress is never shortened. Out-of-range ratios are repaired when they are captured: B below 3 becomes 3, and A above the repaired B becomes B.

The control FSM has three states.
- IDLE: nothing counts and both outputs are low.
- SWALLOW: the prescaler divides by P+1 and `mod_ctl` is high.
- MAIN: the prescaler divides by P.

It has these transitions.
- IDLE→SWALLOW: load with A non-zero.
- IDLE→MAIN: load with A zero.
- SWALLOW→MAIN: the swallow count is exhausted before the period ends.
- SWALLOW→SWALLOW and MAIN→SWALLOW: a period ends and the next A is non-zero.
- SWALLOW→MAIN and MAIN→MAIN: a period ends and the next A is zero.

Reset returns the FSM to IDLE.

Top module: `pswdiv_top`

## Requirements
- R1: After reset, and until the first load, `div_out` and `mod_ctl` stay low and no pulse is produced.
- R2: While counting, the distance between consecutive `div_out` pulses is P×B+A input cycles. P is 32 when `wide_sel` was 0 at load time and 64 when it was 1.
- R3: A load accepted in IDLE starts counting at once. The first pulse is high in the cycle that begins P×B+A clock edges after the edge that sampled `load`.
- R4: `div_out` is high for exactly one clock cycle per period.
- R5: In each period, `mod_ctl` is high for exactly A×(P+1) cycles, contiguously from the start of the period. A rise of `mod_ctl` only happens at a period start.
- R6: A load while counting does not change the period in progress. The new values govern the following period.
- R7: A value of `main_b` below 3 (0, 1 or 2) is treated as 3.
- R8: A value of `swallow_a` greater than the effective B is treated as equal to B.
- R9: With A equal to 0, `mod_ctl` stays low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided input clock; one edge per input cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Ratio capture strobe, one cycle |
| swallow_a | input | 6 | Swallow count A, unsigned binary |
| main_b | input | 6 | Main count B, unsigned binary |
| wide_sel | input | 1 | Prescaler select: 0 gives 32/33, 1 gives 64/65 |
| div_out | output | 1 | One-cycle pulse at the end of each period |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |

## Verification
The near-exhaustive sweep uses the narrow prescaler. It covers every B from 0 to 6 and, for each B, every A from 0 up to two past B. This separates a correct P×B+A from an off-by-one prescaler limit, from a swallow counter that stops one event early or late, and from missing or wrong clamping of B and A. A few wide-prescaler and full-scale ratios (63/63) show that P really switches to 64 and that large counts do not wrap. Each new ratio is loaded in the middle of a running period. The length of that period is compared with the old ratio, which separates staged loading from loading that takes effect early. The `mod_ctl` high-time per period tells apart swallow timing that is correct in total but wrong in its P+1 share.

// File: rtl/pswdiv_pkg.sv
package pswdiv_pkg;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_SWALLOW = 2'd1,
        PS_MAIN    = 2'd2
    } ps_state_t;

endpackage

// File: rtl/pswdiv_sanitize.sv
module pswdiv_sanitize #(
    parameter int CNT_W = 6,
    parameter int B_MIN = 3
) (
    input  logic [CNT_W-1:0] raw_a,
    input  logic [CNT_W-1:0] raw_b,
    output logic [CNT_W-1:0] clean_a,
    output logic [CNT_W-1:0] clean_b
);

    localparam logic [CNT_W-1:0] B_FLOOR = CNT_W'(B_MIN);

    always_comb begin
        clean_b = (raw_b < B_FLOOR) ? B_FLOOR : raw_b;
        clean_a = (raw_a > clean_b) ? clean_b : raw_a;
    end

endmodule

// File: rtl/pswdiv_prescaler.sv
module pswdiv_prescaler #(
    parameter int P_NARROW = 32,
    parameter int P_WIDE   = 64,
    parameter int PRE_W    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wide,
    input  logic mod_hi,
    output logic tc
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] base;
    logic [PRE_W-1:0] limit;

    always_comb begin
        base  = wide ? PRE_W'(P_WIDE) : PRE_W'(P_NARROW);
        limit = base + PRE_W'(mod_hi) - PRE_W'(1);
        tc    = run && (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pswdiv_ctrl.sv
module pswdiv_ctrl
    import pswdiv_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] clean_a,
    input  logic [CNT_W-1:0] clean_b,
    input  logic             wide_in,
    input  logic             tc,
    input  logic             period_end,
    output ps_state_t        state,
    output logic [CNT_W-1:0] b_left,
    output logic             cur_wide
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ps_state_t        state_nx;
    logic [CNT_W-1:0] a_left;
    logic [CNT_W-1:0] pend_a;
    logic [CNT_W-1:0] pend_b;
    logic             pend_w;
    logic [CNT_W-1:0] nxt_a;
    logic [CNT_W-1:0] nxt_b;
    logic             nxt_w;

    // values for the next period: a load in the boundary cycle wins
    always_comb begin
        nxt_a = load ? clean_a : pend_a;
        nxt_b = load ? clean_b : pend_b;
        nxt_w = load ? wide_in : pend_w;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: begin
                if (load) begin
                    state_nx = (clean_a != '0) ? PS_SWALLOW : PS_MAIN;
                end
            end
            PS_SWALLOW: begin
                if (period_end) begin
                    state_nx = (nxt_a != '0) ? PS_SWALLOW : PS_MAIN;
                end else if (tc && (a_left == ONE)) begin
                    state_nx = PS_MAIN;
                end
            end
            PS_MAIN: begin
                if (period_end) begin
                    state_nx = (nxt_a != '0) ? PS_SWALLOW : PS_MAIN;
                end
            end
            default: state_nx = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a <= '0;
            pend_b <= '0;
            pend_w <= 1'b0;
        end else if (load) begin
            pend_a <= clean_a;
            pend_b <= clean_b;
            pend_w <= wide_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_left   <= '0;
            b_left   <= '0;
            cur_wide <= 1'b0;
        end else if ((state == PS_IDLE) && load) begin
            a_left   <= clean_a;
            b_left   <= clean_b;
            cur_wide <= wide_in;
        end else if (period_end) begin
            a_left   <= nxt_a;
            b_left   <= nxt_b;
            cur_wide <= nxt_w;
        end else if ((state != PS_IDLE) && tc) begin
            b_left <= b_left - ONE;
            if (state == PS_SWALLOW) begin
                a_left <= a_left - ONE;
            end
        end
    end

endmodule

// File: rtl/pswdiv_top.sv
module pswdiv_top
    import pswdiv_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int B_MIN    = 3,
    parameter int P_NARROW = 32,
    parameter int P_WIDE   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] swallow_a,
    input  logic [CNT_W-1:0] main_b,
    input  logic             wide_sel,
    output logic             div_out,
    output logic             mod_ctl
);

    localparam int PRE_W = $clog2(P_WIDE + 2);

    logic [CNT_W-1:0] clean_a;
    logic [CNT_W-1:0] clean_b;
    logic [CNT_W-1:0] b_left;
    logic             cur_wide;
    logic             tc;
    logic             period_end;
    logic             running;
    logic             div_q;
    ps_state_t        state;

    pswdiv_sanitize #(
        .CNT_W (CNT_W),
        .B_MIN (B_MIN)
    ) u_san (
        .raw_a   (swallow_a),
        .raw_b   (main_b),
        .clean_a (clean_a),
        .clean_b (clean_b)
    );

    pswdiv_prescaler #(
        .P_NARROW (P_NARROW),
        .P_WIDE   (P_WIDE),
        .PRE_W    (PRE_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .wide   (cur_wide),
        .mod_hi (mod_ctl),
        .tc     (tc)
    );

    pswdiv_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .clean_a    (clean_a),
        .clean_b    (clean_b),
        .wide_in    (wide_sel),
        .tc         (tc),
        .period_end (period_end),
        .state      (state),
        .b_left     (b_left),
        .cur_wide   (cur_wide)
    );

    always_comb begin
        running    = (state != PS_IDLE);
        mod_ctl    = (state == PS_SWALLOW);
        period_end = running && tc && (b_left == CNT_W'(1));
    end

    // output process: registered divided pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else begin
            div_q <= period_end;
        end
    end

    assign div_out = div_q;

endmodule

// File: rtl/pswdiv_checker.sv
module pswdiv_checker
    import pswdiv_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             div_out,
    input logic             mod_ctl,
    input ps_state_t        state,
    input logic [CNT_W-1:0] b_left
);

    logic started;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (load) begin
            started <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!div_out && !mod_ctl));

    assert_pulse_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> started);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    assert_mod_rise_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> (div_out || $past(load)));

    assert_main_count_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_IDLE) |-> (b_left != '0));

endmodule

bind pswdiv_top pswdiv_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .div_out (div_out),
    .mod_ctl (mod_ctl),
    .state   (state),
    .b_left  (b_left)
);

// File: tb/sim_pswdiv_top.sv
module sim_pswdiv_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic       wide_sel = 1'b0;
    logic [5:0] swallow_a = '0;
    logic [5:0] main_b = '0;
    logic       div_out;
    logic       mod_ctl;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_pulse = 0;
    int interval = 0;
    int mod_acc = 0;
    int mod_last = 0;
    int width_err = 0;
    int prev_n = 0;
    bit pulse_now = 0;
    bit prev_div = 0;

    always #4 clk = ~clk;

    pswdiv_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .swallow_a (swallow_a),
        .main_b    (main_b),
        .wide_sel  (wide_sel),
        .div_out   (div_out),
        .mod_ctl   (mod_ctl)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        pulse_now = div_out;
        if (div_out && prev_div) width_err++;
        prev_div = div_out;
        if (div_out) begin
            interval   = cyc - last_pulse;
            last_pulse = cyc;
            mod_last   = mod_acc;
            mod_acc    = mod_ctl ? 1 : 0;
        end else begin
            mod_acc += mod_ctl ? 1 : 0;
        end
    endtask

    task automatic wait_pulse(input string req);
        int k = 0;
        do begin
            step();
            k++;
        end while (!pulse_now && k < 10000);
        if (!pulse_now) check(0, 1, req);
    endtask

    function automatic int eff_b(input int b);
        return (b < 3) ? 3 : b;
    endfunction

    function automatic int eff_a(input int a, input int b);
        return (a > eff_b(b)) ? eff_b(b) : a;
    endfunction

    task automatic run_cfg(input int a, input int b, input int w, input bit first);
        int p;
        int n;
        int m;
        int ld_edge;
        string tag;
        string mtag;
        p    = (w != 0) ? 64 : 32;
        n    = p * eff_b(b) + eff_a(a, b);
        m    = eff_a(a, b) * (p + 1);
        tag  = (b < 3) ? "R7 clamp B" : ((a > b) ? "R8 clamp A" : "R2 period");
        mtag = (eff_a(a, b) == 0) ? "R9 no swallow" : "R5 swallow time";
        swallow_a = 6'(a);
        main_b    = 6'(b);
        wide_sel  = (w != 0);
        load      = 1'b1;
        step();
        ld_edge = cyc;
        load    = 1'b0;
        if (first) begin
            wait_pulse("R3 timeout");
            check(cyc - ld_edge, n, "R3 first pulse after load");
        end else begin
            wait_pulse("R6 timeout");
            check(interval, prev_n, "R6 period in progress kept");
        end
        wait_pulse("R2 timeout");
        check(interval, n, tag);
        check(mod_last, m, mtag);
        prev_n = n;
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) step();
        check(int'(div_out), 0, "R1 reset div_out");
        check(int'(mod_ctl), 0, "R1 reset mod_ctl");
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            seen += (div_out || mod_ctl) ? 1 : 0;
        end
        check(seen, 0, "R1 idle before load");

        run_cfg(5, 10, 0, 1'b1);
        for (int b = 0; b <= 6; b++) begin
            for (int a = 0; a <= b + 2; a++) begin
                run_cfg(a, b, 0, 1'b0);
            end
        end
        run_cfg(0, 3, 1, 1'b0);
        run_cfg(3, 3, 1, 1'b0);
        run_cfg(17, 40, 1, 1'b0);
        run_cfg(63, 63, 1, 1'b0);
        run_cfg(63, 63, 0, 1'b0);
        run_cfg(1, 63, 0, 1'b0);
        run_cfg(0, 5, 1, 1'b0);
        run_cfg(7, 2, 1, 1'b0);

        check(width_err, 0, "R4 pulse width");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule